// File: doc/BRIEF.md
# FIFO Readout Register Bank

This block is the host-facing register front end for a pair of show-ahead FIFOs (a wide trigger-record FIFO and a narrower veto-record FIFO) and a small set of run statistics. A host issues single-word reads and writes over a simple strobe, address and data interface. Every read returns one 16-bit word, so the 80-bit trigger head, the 48-bit veto head, the two occupancy counts, the 48-bit live-time and dead-time scalers and the lost-trigger count are each split into fixed 16-bit slices at their own addresses.

Reading never disturbs a FIFO. The head stays visible and unchanged until the host writes to one of two pop addresses. Such a write produces a single-cycle read-request pulse toward the matching FIFO, whatever data value it carries. Pop writes that would take an entry from an empty FIFO produce no pulse. This includes a second pop issued while the pulse for the last entry is still in flight. The FIFO storage, the network transport and the command parsing all sit outside this block.

Top module: `fifo_readout_bank`

## Requirements
- R1: A read strobe returns its word on `rd_data` with `rd_valid` high exactly one cycle later. `rd_valid` is low in every cycle that does not follow a read strobe.
- R2: Addresses 0 to 4 return trigger head slices, where address k returns bits [16k+15:16k] of `trig_head`. Address 0 holds bits 15:0 and address 4 holds bits 79:64.
- R3: Addresses 5 to 7 return veto head slices, where address 5+k returns bits [16k+15:16k] of `veto_head`.
- R4: Address 8 returns `trig_fill` and address 9 returns `veto_fill`, each zero-extended to 16 bits.
- R5: Addresses 10 to 12 return `live_time` and addresses 13 to 15 return `dead_time`, least significant word first.
- R6: Address 16 returns `lost_trig`.
- R7: A read of any address from 17 to 31 returns 0x0000.
- R8: Reads never produce a pop pulse. Repeated reads of a head word return the same value.
- R9: A write to address 17 while the trigger FIFO holds an entry raises `trig_pop` for exactly one cycle, the cycle after the write. The written data value has no effect.
- R10: A write to address 18 while the veto FIFO holds an entry raises `veto_pop` for exactly one cycle, the cycle after the write. It leaves `trig_pop` low.
- R11: No pop pulse is produced when the fill count is 0. No pulse is produced either when the fill count is 1 and a pulse for that entry is already high.
- R12: After reset, `rd_data` is 0x0000 and `rd_valid`, `trig_pop` and `veto_pop` are low.
- R13: A write to any address other than 17 or 18 produces no pop pulse and no read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_addr | input | 5 | Register address |
| host_wdata | input | 16 | Write data (ignored by pop writes) |
| trig_head | input | 80 | Current trigger FIFO head (show-ahead) |
| trig_fill | input | 9 | Entries held in the trigger FIFO |
| veto_head | input | 48 | Current veto FIFO head (show-ahead) |
| veto_fill | input | 9 | Entries held in the veto FIFO |
| live_time | input | 48 | Live-time scaler |
| dead_time | input | 48 | Dead-time scaler |
| lost_trig | input | 16 | Lost-trigger count |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rd_data carries a read result |
| trig_pop | output | 1 | Single-cycle read request to the trigger FIFO |
| veto_pop | output | 1 | Single-cycle read request to the veto FIFO |

## Verification
Read data and `rd_valid` are due one clock after the read strobe. Pop pulses are due one clock after the write and must be gone one clock later. The FIFO model in the bench updates its fill count and head at the edge that sees a pulse, so the effect of a pop becomes visible at the next sample. Inputs are driven on the falling edge and every result is sampled on the falling edge that follows the registering rising edge. Each check therefore lands exactly on the cycle its result is due, never earlier or later.

// File: rtl/fifo_readout_pkg.sv
package fifo_readout_pkg;
  localparam int WORD_W = 16;

  function automatic int words_for(input int bits);
    return (bits + WORD_W - 1) / WORD_W;
  endfunction
endpackage

// File: rtl/head_slicer.sv
// Zero-pads a source value to a whole number of host words.
module head_slicer
  import fifo_readout_pkg::*;
#(
  parameter int SRC_W     = 80,
  parameter int NUM_WORDS = 5
) (
  input  logic [SRC_W-1:0]            src,
  output logic [NUM_WORDS*WORD_W-1:0] flat
);
  localparam int PAD_W = NUM_WORDS * WORD_W - SRC_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign flat = {{PAD_W{1'b0}}, src};
    end else begin : g_exact
      assign flat = src;
    end
  endgenerate
endmodule

// File: rtl/pop_gate.sv
// Turns a write to one pop address into a single-cycle request pulse.
module pop_gate #(
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 9,
  parameter int POP_ADDR = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  fill,
  output logic              pop
);
  logic hit;
  logic room;

  assign hit  = wr_en && (wr_addr == ADDR_W'(POP_ADDR));
  // The last entry may already be leaving via the pulse now high.
  assign room = (fill != '0) && !(pop && (fill == CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) pop <= 1'b0;
    else     pop <= hit && room;
  end

  assert_pop_needs_write_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> $past(wr_en && (wr_addr == ADDR_W'(POP_ADDR))));

  assert_no_empty_pop_R11: assert property (@(posedge clk) disable iff (rst)
    pop |-> (fill != '0));

  assert_empty_write_silent_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == ADDR_W'(POP_ADDR)) && (fill == '0)) |=> !pop);
endmodule

// File: rtl/read_mux.sv
// Registered word select over a flat table of host words.
module read_mux
  import fifo_readout_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 17
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NUM_REGS*WORD_W-1:0] table_flat,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       rd_valid
);
  logic              mapped;
  logic [WORD_W-1:0] picked;

  assign mapped = int'(rd_addr) < NUM_REGS;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(rd_addr) == i) picked = table_flat[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mapped ? picked : '0;
    end
  end

  assert_valid_after_read_R1: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_valid_needs_read_R1: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rd_data == '0));
endmodule

// File: rtl/fifo_readout_bank.sv
module fifo_readout_bank
  import fifo_readout_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int TRIG_W     = 80,
  parameter int VETO_W     = 48,
  parameter int TRIG_DEPTH = 256,
  parameter int VETO_DEPTH = 256,
  parameter int SCALER_W   = 48,
  parameter int LOST_W     = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              host_rd,
  input  logic                              host_wr,
  input  logic [ADDR_W-1:0]                 host_addr,
  input  logic [WORD_W-1:0]                 host_wdata,
  input  logic [TRIG_W-1:0]                 trig_head,
  input  logic [$clog2(TRIG_DEPTH+1)-1:0]   trig_fill,
  input  logic [VETO_W-1:0]                 veto_head,
  input  logic [$clog2(VETO_DEPTH+1)-1:0]   veto_fill,
  input  logic [SCALER_W-1:0]               live_time,
  input  logic [SCALER_W-1:0]               dead_time,
  input  logic [LOST_W-1:0]                 lost_trig,
  output logic [WORD_W-1:0]                 rd_data,
  output logic                              rd_valid,
  output logic                              trig_pop,
  output logic                              veto_pop
);
  localparam int TCNT_W   = $clog2(TRIG_DEPTH + 1);
  localparam int VCNT_W   = $clog2(VETO_DEPTH + 1);
  localparam int TRIG_NW  = words_for(TRIG_W);
  localparam int VETO_NW  = words_for(VETO_W);
  localparam int TCNT_NW  = words_for(TCNT_W);
  localparam int VCNT_NW  = words_for(VCNT_W);
  localparam int SCAL_NW  = words_for(SCALER_W);
  localparam int LOST_NW  = words_for(LOST_W);
  localparam int NUM_REGS = TRIG_NW + VETO_NW + TCNT_NW + VCNT_NW
                          + 2 * SCAL_NW + LOST_NW;
  localparam int TRIG_POP_ADDR = NUM_REGS;
  localparam int VETO_POP_ADDR = NUM_REGS + 1;

  logic [TRIG_NW*WORD_W-1:0]  trig_flat;
  logic [VETO_NW*WORD_W-1:0]  veto_flat;
  logic [TCNT_NW*WORD_W-1:0]  tcnt_flat;
  logic [VCNT_NW*WORD_W-1:0]  vcnt_flat;
  logic [SCAL_NW*WORD_W-1:0]  live_flat;
  logic [SCAL_NW*WORD_W-1:0]  dead_flat;
  logic [LOST_NW*WORD_W-1:0]  lost_flat;
  logic [NUM_REGS*WORD_W-1:0] table_flat;

  head_slicer #(.SRC_W(TRIG_W),   .NUM_WORDS(TRIG_NW)) u_trig (.src(trig_head), .flat(trig_flat));
  head_slicer #(.SRC_W(VETO_W),   .NUM_WORDS(VETO_NW)) u_veto (.src(veto_head), .flat(veto_flat));
  head_slicer #(.SRC_W(TCNT_W),   .NUM_WORDS(TCNT_NW)) u_tcnt (.src(trig_fill), .flat(tcnt_flat));
  head_slicer #(.SRC_W(VCNT_W),   .NUM_WORDS(VCNT_NW)) u_vcnt (.src(veto_fill), .flat(vcnt_flat));
  head_slicer #(.SRC_W(SCALER_W), .NUM_WORDS(SCAL_NW)) u_live (.src(live_time), .flat(live_flat));
  head_slicer #(.SRC_W(SCALER_W), .NUM_WORDS(SCAL_NW)) u_dead (.src(dead_time), .flat(dead_flat));
  head_slicer #(.SRC_W(LOST_W),   .NUM_WORDS(LOST_NW)) u_lost (.src(lost_trig), .flat(lost_flat));

  // Word 0 sits in the low bits: trigger, veto, counts, live, dead, lost.
  assign table_flat = {lost_flat, dead_flat, live_flat, vcnt_flat, tcnt_flat,
                       veto_flat, trig_flat};

  read_mux #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_mux (
    .clk(clk), .rst(rst), .rd_en(host_rd), .rd_addr(host_addr),
    .table_flat(table_flat), .rd_data(rd_data), .rd_valid(rd_valid));

  pop_gate #(.ADDR_W(ADDR_W), .CNT_W(TCNT_W), .POP_ADDR(TRIG_POP_ADDR)) u_tpop (
    .clk(clk), .rst(rst), .wr_en(host_wr), .wr_addr(host_addr),
    .fill(trig_fill), .pop(trig_pop));

  // R10: veto pop path, same gate on its own address and fill count.
  pop_gate #(.ADDR_W(ADDR_W), .CNT_W(VCNT_W), .POP_ADDR(VETO_POP_ADDR)) u_vpop (
    .clk(clk), .rst(rst), .wr_en(host_wr), .wr_addr(host_addr),
    .fill(veto_fill), .pop(veto_pop));

  assert_wdata_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (host_wr && (host_addr == ADDR_W'(TRIG_POP_ADDR)) && (trig_fill > TCNT_W'(1))
     && (host_wdata != '0)) |=> trig_pop);

  assert_read_no_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_wr) |=> (!trig_pop && !veto_pop));

  assert_veto_pop_only_R10: assert property (@(posedge clk) disable iff (rst)
    (host_wr && (host_addr == ADDR_W'(VETO_POP_ADDR))) |=> !trig_pop);
endmodule

// File: tb/tb_fifo_readout_bank.sv
`timescale 1ns/1ps
module tb_fifo_readout_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [79:0] trig_head;
  logic [47:0] veto_head;
  logic [8:0]  tcnt = '0, vcnt = '0;
  logic [47:0] live_time = '0, dead_time = '0;
  logic [15:0] lost_trig = '0;
  logic [15:0] rd_data;
  logic        rd_valid, trig_pop, veto_pop;

  logic [15:0] tidx = '0, vidx = '0;
  logic        t_load = 1'b0, v_load = 1'b0;
  logic [8:0]  t_load_val = '0, v_load_val = '0;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fifo_readout_bank dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .trig_head(trig_head), .trig_fill(tcnt), .veto_head(veto_head),
    .veto_fill(vcnt), .live_time(live_time), .dead_time(dead_time),
    .lost_trig(lost_trig), .rd_data(rd_data), .rd_valid(rd_valid),
    .trig_pop(trig_pop), .veto_pop(veto_pop));

  function automatic logic [15:0] tw(input logic [15:0] i, input int k);
    return 16'(i * 16'h0123 + k * 16'h1010 + 16'h0a05);
  endfunction
  function automatic logic [15:0] vw(input logic [15:0] i, input int k);
    return 16'(i * 16'h0311 + k * 16'h2222 + 16'h00c3);
  endfunction

  always_comb begin
    for (int k = 0; k < 5; k++) trig_head[16*k +: 16] = tw(tidx, k);
    for (int k = 0; k < 3; k++) veto_head[16*k +: 16] = vw(vidx, k);
  end

  // Show-ahead FIFO model: a pulse seen at an edge retires the head.
  always @(posedge clk) begin
    if (t_load) tcnt <= t_load_val;
    else if (trig_pop && tcnt != 0) begin tcnt <= tcnt - 1; tidx <= tidx + 1; end
    if (v_load) vcnt <= v_load_val;
    else if (veto_pop && vcnt != 0) begin vcnt <= vcnt - 1; vidx <= vidx + 1; end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int a);
    if (a < 5)       return tw(tidx, a);
    else if (a < 8)  return vw(vidx, a - 5);
    else if (a == 8) return {7'b0, tcnt};
    else if (a == 9) return {7'b0, vcnt};
    else if (a < 13) return live_time[16*(a-10) +: 16];
    else if (a < 16) return dead_time[16*(a-13) +: 16];
    else if (a == 16) return lost_trig;
    return 16'h0000;
  endfunction

  function automatic string tag_of(input int a);
    if (a < 5)        return "R2 trig word";
    else if (a < 8)   return "R3 veto word";
    else if (a < 10)  return "R4 fill";
    else if (a < 16)  return "R5 scaler";
    else if (a == 16) return "R6 lost";
    return "R7 unmapped";
  endfunction

  task automatic load_fill(input logic [8:0] t, input logic [8:0] v);
    @(negedge clk);
    t_load = 1'b1; t_load_val = t; v_load = 1'b1; v_load_val = v;
    @(negedge clk);
    t_load = 1'b0; v_load = 1'b0;
  endtask

  task automatic do_read(input int a);
    logic [15:0] e;
    @(negedge clk);
    host_rd = 1'b1; host_addr = 5'(a);
    e = exp_word(a);
    @(negedge clk);
    host_rd = 1'b0;
    check("R1 valid", rd_valid, 1);
    check(tag_of(a), rd_data, e);
    check("R8 no pop on read", {trig_pop, veto_pop}, 0);
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input bit et, input bit ev, input string req);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    check({req, " pulse"}, {trig_pop, veto_pop}, {et, ev});
    check("R13 no read response", rd_valid, 0);
    @(negedge clk);
    check({req, " single cycle"}, {trig_pop, veto_pop}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 rd_data reset", rd_data, 0);
    check("R12 rd_valid reset", rd_valid, 0);
    check("R12 pops reset", {trig_pop, veto_pop}, 0);

    // Full address sweep under three statistic patterns.
    for (int p = 0; p < 3; p++) begin
      live_time = 48'h1234_5678_9abc + 48'(p) * 48'h1111_0101_0011;
      dead_time = 48'hfedc_ba98_7654 - 48'(p) * 48'h0203_0405_0607;
      lost_trig = 16'h8001 + 16'(p) * 16'h0707;
      load_fill(9'(4 + p * 100), 9'(3 + p * 50));
      for (int a = 0; a < 32; a++) do_read(a);
    end
    @(negedge clk);
    check("R1 valid idle", rd_valid, 0);

    // Repeated reads of the head do not advance it.
    load_fill(9'd4, 9'd3);
    for (int r = 0; r < 3; r++) do_read(0);
    check("R8 fill unchanged", tcnt, 4);

    // Drain the trigger FIFO, nonzero data each time, reading the head after every pop.
    for (int n = 0; n < 4; n++) begin
      do_write(17, 16'hffff - 16'(n), 1'b1, 1'b0, "R9 trig pop");
      for (int a = 0; a < 5; a++) do_read(a);
      do_read(8);
    end
    do_write(17, 16'h1234, 1'b0, 1'b0, "R11 empty trig pop");
    check("R11 trig fill stays 0", tcnt, 0);

    // Drain the veto FIFO.
    for (int n = 0; n < 3; n++) begin
      do_write(18, 16'(n), 1'b0, 1'b1, "R10 veto pop");
      for (int a = 5; a < 8; a++) do_read(a);
      do_read(9);
    end
    do_write(18, 16'h0, 1'b0, 1'b0, "R11 empty veto pop");

    // Writes elsewhere do nothing.
    load_fill(9'd5, 9'd5);
    do_write(3, 16'hbeef, 1'b0, 1'b0, "R13 write addr 3");
    do_write(16, 16'hbeef, 1'b0, 1'b0, "R13 write addr 16");
    do_write(25, 16'hbeef, 1'b0, 1'b0, "R13 write addr 25");
    check("R13 fills kept", {tcnt, vcnt}, {9'd5, 9'd5});

    // Back-to-back pops with one and two entries left.
    for (int c = 1; c <= 2; c++) begin
      load_fill(9'(c), 9'd0);
      @(negedge clk);
      host_wr = 1'b1; host_addr = 5'd17; host_wdata = 16'h5555;
      @(negedge clk);
      check("R11 b2b first pulse", trig_pop, 1);
      @(negedge clk);
      host_wr = 1'b0;
      check("R11 b2b second pulse", trig_pop, (c == 2) ? 1 : 0);
      @(negedge clk);
      check("R11 b2b end", trig_pop, 0);
      check("R11 b2b fill", tcnt, 0);
    end

    // Read and pop in the same cycle.
    load_fill(9'd2, 9'd2);
    @(negedge clk);
    host_rd = 1'b1; host_wr = 1'b1; host_addr = 5'd18;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    check("R10 veto pop with read", {trig_pop, veto_pop}, 2'b01);
    check("R7 read of pop addr", {rd_valid, rd_data}, {1'b1, 16'h0});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule